// File: doc/BRIEF.md
# Conversion Result Queue with Status Word

This block buffers digitized samples from one sample sequencer until software collects them. The converter side offers each result with a valid strobe. The reader side sees the oldest stored result on a 32-bit data word, and one read strobe removes it. Results leave in the order they were captured: sample 0, then sample 1, and so on. A packed 32-bit status word reports fill state together with the raw write and read indices. A separate pair of sticky error flags records misuse, and software clears them by writing ones.

Both data paths use valid/ready naming, with one difference from normal stream practice. The converter cannot stall, so `in_ready` is advisory. An offer made while `in_ready` is low is dropped and logged, and the source is not held. On the read side `out_valid` shows that data is waiting. A read strobe on `out_ready` while `out_valid` is low is an error read: it returns zero and is logged. Storage depth is a parameter of 2 to 16 entries, so the indices always fit their 4-bit status fields. The data field width is a parameter.

Top module: `adcf_result_fifo`

## Requirements
- R1: `out_word` carries the oldest unread result in bits DATA_W-1:0, and all higher bits read as zero. While the queue is empty, `out_word` is zero.
- R2: Each accepted read strobe removes exactly one entry. Results are returned in capture order, including after the indices wrap.
- R3: `stat_word` holds the read index in bits 3:0, the write index in bits 7:4, the empty flag in bit 8 and the full flag in bit 12. Every other bit is zero.
- R4: After reset, `stat_word` reads 0x100 and `err_flags` reads 0.
- R5: The write index names the next slot to be filled, and the read index names the next slot to be read. Each accepted write or read advances its index by one, and the index returns from DEPTH-1 to 0.
- R6: An offer while full is discarded, the write index stays unchanged, and the overflow flag (`err_flags` bit 0) is set. This holds even if a read happens in the same cycle.
- R7: A read strobe while empty returns zero, leaves the read index unchanged, and sets the underflow flag (`err_flags` bit 1).
- R8: Each error flag stays set until a cycle in which `clr_valid` is high with a one in its `clr_mask` bit. A zero mask bit leaves its flag unchanged. A new error in the same cycle as a clear keeps the flag set.
- R9: A write and a read accepted in the same cycle on a partly filled queue advance both indices, and the occupancy stays the same.
- R10: `in_ready` is low exactly when the queue is full, and `out_valid` is high exactly when it is not empty.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | A conversion result is offered this cycle |
| in_data | input | DATA_W | Offered conversion result |
| in_ready | output | 1 | Space is available (advisory; the source does not stall) |
| out_ready | input | 1 | Read strobe: remove the entry shown on `out_word` |
| out_valid | output | 1 | At least one result is stored |
| out_word | output | 32 | Oldest result, zero-extended |
| stat_word | output | 32 | Packed full/empty flags and the two indices |
| clr_valid | input | 1 | Write strobe for the error flag register |
| clr_mask | input | 2 | Write-one-to-clear mask: bit 0 overflow, bit 1 underflow |
| err_flags | output | 2 | Sticky error flags: bit 0 overflow, bit 1 underflow |

## Verification
The bench builds the block with DEPTH = 4 and DATA_W = 10. The small depth lets a few writes reach the full state, and both indices wrap several times during a short stream of combined writes and reads. That puts ordering across the wrap, a drop while full that coincides with a read, and a clear that collides with a new underflow all within a few dozen cycles. With 10-bit results, checks on patterns such as 0x3FF also show that bits above the data field stay at zero.

// File: rtl/adcf_pkg.sv
package adcf_pkg;
  localparam int WORD_W      = 32;
  localparam int IDX_FIELD_W = 4;
  localparam int MAX_DEPTH   = 16;
  localparam int ST_RD_LSB   = 0;
  localparam int ST_WR_LSB   = 4;
  localparam int ST_EMPTY    = 8;
  localparam int ST_FULL     = 12;
  localparam int ERR_W       = 2;
  localparam int ERR_OVF     = 0;
  localparam int ERR_UNF     = 1;

  typedef struct packed {
    logic                   full;
    logic                   empty;
    logic [IDX_FIELD_W-1:0] wr_idx;
    logic [IDX_FIELD_W-1:0] rd_idx;
  } q_state_t;
endpackage

// File: rtl/adcf_store.sv
module adcf_store
  import adcf_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int DATA_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push_req,
  input  logic [DATA_W-1:0] push_data,
  input  logic              pop_req,
  output logic [DATA_W-1:0] rd_data,
  output q_state_t          state,
  output logic              push_drop,
  output logic              pop_miss
);
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int OCC_W = $clog2(DEPTH + 1);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DEPTH - 1);
  localparam logic [OCC_W-1:0] FULL_OCC = OCC_W'(DEPTH);

  logic [DATA_W-1:0] slots [DEPTH];
  logic [IDX_W-1:0]  wr_q, rd_q;
  logic [OCC_W-1:0]  occ_q;
  logic              full, empty, push_ok, pop_ok;

  function automatic logic [IDX_W-1:0] step_idx(input logic [IDX_W-1:0] p);
    return (p == LAST_IDX) ? '0 : p + IDX_W'(1);
  endfunction

  assign full    = (occ_q == FULL_OCC);
  assign empty   = (occ_q == '0);
  assign push_ok = push_req && !full;
  assign pop_ok  = pop_req && !empty;
  assign push_drop = push_req && full;
  assign pop_miss  = pop_req && empty;

  always_ff @(posedge clk) begin
    if (push_ok) slots[wr_q] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      occ_q <= '0;
    end else begin
      if (push_ok) wr_q <= step_idx(wr_q);
      if (pop_ok)  rd_q <= step_idx(rd_q);
      case ({push_ok, pop_ok})
        2'b10:   occ_q <= occ_q + OCC_W'(1);
        2'b01:   occ_q <= occ_q - OCC_W'(1);
        default: occ_q <= occ_q;
      endcase
    end
  end

  assign rd_data      = empty ? '0 : slots[rd_q];
  assign state.full   = full;
  assign state.empty  = empty;
  assign state.wr_idx = IDX_FIELD_W'(wr_q);
  assign state.rd_idx = IDX_FIELD_W'(rd_q);

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (full && push_req) |=> $stable(wr_q)); // R6
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && pop_req) |=> $stable(rd_q)); // R7
  AST_BOTH_KEEP_OCC: assert property (@(posedge clk) disable iff (!rst_n)
    (push_ok && pop_ok) |=> $stable(occ_q)); // R9
  AST_WR_ADVANCES: assert property (@(posedge clk) disable iff (!rst_n)
    push_ok |=> (wr_q != $past(wr_q))); // R5
endmodule

// File: rtl/adcf_errs.sv
module adcf_errs
  import adcf_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [ERR_W-1:0] set_bits,
  input  logic             clr_valid,
  input  logic [ERR_W-1:0] clr_mask,
  output logic [ERR_W-1:0] flags
);
  logic [ERR_W-1:0] flags_q;

  for (genvar b = 0; b < ERR_W; b++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                         flags_q[b] <= 1'b0;
      else if (set_bits[b])               flags_q[b] <= 1'b1;
      else if (clr_valid && clr_mask[b])  flags_q[b] <= 1'b0;
    end
  end

  assign flags = flags_q;

  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (flags_q[ERR_OVF] && !(clr_valid && clr_mask[ERR_OVF])) |=> flags_q[ERR_OVF]); // R8
  AST_OVF_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    set_bits[ERR_OVF] |=> flags_q[ERR_OVF]); // R6
  AST_UNF_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    set_bits[ERR_UNF] |=> flags_q[ERR_UNF]); // R7
endmodule

// File: rtl/adcf_pack.sv
module adcf_pack
  import adcf_pkg::*;
#(
  parameter int DATA_W = 10
) (
  input  q_state_t           state,
  input  logic [DATA_W-1:0]  rd_data,
  output logic [WORD_W-1:0]  out_word,
  output logic [WORD_W-1:0]  stat_word
);
  always_comb begin
    stat_word = '0;
    stat_word[ST_RD_LSB +: IDX_FIELD_W] = state.rd_idx;
    stat_word[ST_WR_LSB +: IDX_FIELD_W] = state.wr_idx;
    stat_word[ST_EMPTY]                 = state.empty;
    stat_word[ST_FULL]                  = state.full;
  end

  always_comb begin
    out_word = '0;
    out_word[DATA_W-1:0] = rd_data;
  end
endmodule

// File: rtl/adcf_result_fifo.sv
module adcf_result_fifo
  import adcf_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int DATA_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  output logic              in_ready,
  input  logic              out_ready,
  output logic              out_valid,
  output logic [31:0]       out_word,
  output logic [31:0]       stat_word,
  input  logic              clr_valid,
  input  logic [1:0]        clr_mask,
  output logic [1:0]        err_flags
);
  q_state_t          st;
  logic [DATA_W-1:0] head_data;
  logic              drop, miss;
  logic [ERR_W-1:0]  set_bits;

  adcf_store #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_store (
    .clk(clk), .rst_n(rst_n),
    .push_req(in_valid), .push_data(in_data),
    .pop_req(out_ready), .rd_data(head_data),
    .state(st), .push_drop(drop), .pop_miss(miss)
  );

  always_comb begin
    set_bits          = '0;
    set_bits[ERR_OVF] = drop;
    set_bits[ERR_UNF] = miss;
  end

  adcf_errs u_errs (
    .clk(clk), .rst_n(rst_n), .set_bits(set_bits),
    .clr_valid(clr_valid), .clr_mask(clr_mask), .flags(err_flags)
  );

  adcf_pack #(.DATA_W(DATA_W)) u_pack (
    .state(st), .rd_data(head_data),
    .out_word(out_word), .stat_word(stat_word)
  );

  assign in_ready  = !st.full;
  assign out_valid = !st.empty;

  AST_EMPTY_ZERO_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> (out_word == 32'd0)); // R1
  AST_RD_IDX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !out_ready |=> $stable(stat_word[3:0])); // R5
endmodule

// File: tb/test_adcf_result_fifo.sv
module test_adcf_result_fifo;
  localparam int DEPTH  = 4;
  localparam int DATA_W = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, out_ready = 1'b0, clr_valid = 1'b0;
  logic [DATA_W-1:0] in_data = '0;
  logic [1:0] clr_mask = '0;
  logic in_ready, out_valid;
  logic [31:0] out_word, stat_word;
  logic [1:0] err_flags;

  always #4 clk = ~clk;

  adcf_result_fifo #(.DEPTH(DEPTH), .DATA_W(DATA_W)) i_adcf_result_fifo (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .out_ready(out_ready), .out_valid(out_valid),
    .out_word(out_word), .stat_word(stat_word), .clr_valid(clr_valid),
    .clr_mask(clr_mask), .err_flags(err_flags)
  );

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  logic [DATA_W-1:0] sb[$];
  int m_wr = 0, m_rd = 0, m_occ = 0;
  logic [1:0] m_err = 2'b00;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_stat();
    return {19'd0, (m_occ == DEPTH), 3'd0, (m_occ == 0), 4'(m_wr), 4'(m_rd)};
  endfunction

  // driver + scoreboard: pushes expected items, pops and compares on reads
  task automatic step(bit push, logic [DATA_W-1:0] d, bit pop, bit clr, logic [1:0] mask);
    bit ovf, unf, pok, wok;
    logic [31:0] exp_out;
    @(negedge clk);
    in_valid = push; in_data = d; out_ready = pop; clr_valid = clr; clr_mask = mask;
    #1;
    if (pop) begin
      exp_out = (m_occ > 0) ? {22'd0, sb[0]} : 32'd0;
      if (m_occ > 0) chk("R1 R2 read data in order", out_word, exp_out);
      else           chk("R7 empty read returns zero", out_word, exp_out);
    end
    ovf = push && (m_occ == DEPTH);
    unf = pop && (m_occ == 0);
    wok = push && (m_occ < DEPTH);
    pok = pop && (m_occ > 0);
    @(posedge clk); #2;
    in_valid = 1'b0; out_ready = 1'b0; clr_valid = 1'b0; clr_mask = 2'b00;
    if (pok) begin void'(sb.pop_front()); m_rd = (m_rd + 1) % DEPTH; m_occ--; end
    if (wok) begin sb.push_back(d); m_wr = (m_wr + 1) % DEPTH; m_occ++; end
    m_err = (m_err & ~(clr ? mask : 2'b00)) | {unf, ovf};
    chk("R3 R5 status word", stat_word, exp_stat());
    chk("R6 R7 R8 error flags", {30'd0, err_flags}, {30'd0, m_err});
    chk("R10 ready/valid", {30'd0, in_ready, out_valid}, {30'd0, (m_occ < DEPTH), (m_occ > 0)});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    #1;
    chk("R4 reset status", stat_word, 32'h100);
    chk("R4 reset flags", {30'd0, err_flags}, 32'd0);
    chk("R1 reset data zero", out_word, 32'd0);

    // R2: short burst in, then out
    step(1, 10'h3FF, 0, 0, 2'b00);
    step(1, 10'h155, 0, 0, 2'b00);
    step(1, 10'h2AA, 0, 0, 2'b00);
    for (int i = 0; i < 3; i++) step(0, '0, 1, 0, 2'b00);

    // R6: fill to full, then offer once more
    for (int i = 0; i < DEPTH; i++) step(1, 10'(37 * i + 5), 0, 0, 2'b00);
    step(1, 10'h001, 0, 0, 2'b00);
    // R8: zero mask bit leaves overflow, one clears it
    step(0, '0, 0, 1, 2'b10);
    step(0, '0, 0, 1, 2'b01);
    // R6: offer while full with a read in the same cycle
    step(1, 10'h0F0, 1, 0, 2'b00);
    step(0, '0, 0, 1, 2'b01);

    // R2: drain across the wrap; R7: extra read on empty
    for (int i = 0; i < DEPTH; i++) step(0, '0, 1, 0, 2'b00);
    step(0, '0, 1, 0, 2'b00);
    // R8: new underflow during a clear of the same bit keeps it set
    step(0, '0, 1, 1, 2'b10);
    step(0, '0, 0, 1, 2'b11);

    // R9: combined write and read on a partly filled queue
    step(1, 10'h111, 0, 0, 2'b00);
    for (int i = 0; i < 11; i++) begin
      step(1, 10'(i * 71 + 3), 1, 0, 2'b00);
      chk("R9 occupancy kept", 32'((stat_word[7:4] - stat_word[3:0] + DEPTH) % DEPTH), 32'd1);
    end
    while (m_occ > 0) step(0, '0, 1, 0, 2'b00);

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule